// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers that sits beside a workstation I/O controller. Software reaches it over a plain addressed register bus: a three-bit register index, a two-bit byte offset, a write strobe with 32-bit write data, and 32-bit read data that follows the index in the same cycle. Most registers are plain storage. A few have side effects on write: one strobes the floppy terminal-count line, one requests power-off and clears a latched power-fail condition, and one requests a system reset and keeps a sticky status bit.

A level interrupt goes high while a latched power-fail status bit and a configuration enable bit are both set. The power-fail status follows an external power-fail line, but it is only set while the enable bit is on. The block reset clears the control registers. It spares the diagnostic scratch register, the LED register and the system-control status, so that software can find out after a reset it asked for that this reset took place.

Top module: `sysctl_regbank`

## Requirements
- R1: `irq_o` is high exactly while bit 5 of the power-down register and bit 3 of the configuration register (index 0) are both set. It follows a configuration write, a power-down write or a power-fail input change on the next clock edge.
- R2: When `pfail_i` differs from its value in the previous cycle, bit 5 of the power-down register (index 4) is loaded with `pfail_i` AND the stored configuration bit 3. When the input does not change, the bit stays as it is, except for R4.
- R3: A power-down write stores written bits 0 (power off) and 1 (interrupt clear), stores 0 in bits 2–4, 6 and 7, and keeps the previous bit 5.
- R4: A power-down write with bit 1 set leaves only the written bit 0 in the register, which clears bits 5 and 1.
- R5: A power-down write with bit 0 set produces a one-cycle `pwroff_o` pulse on the edge that accepts the write.
- R6: A write to the auxiliary register (index 3) with bit 1 set produces a one-cycle `tc_o` pulse on the accepting edge. Bit 1 is stored as 0 and the other seven bits are stored as written.
- R7: A write to the system-control register (index 6, offset 0) with bit 0 set loads it with 0x00000002 and produces a one-cycle `rstreq_o` pulse. A write with bit 0 clear changes neither the register nor `rstreq_o`.
- R8: While `rst` is high at a clock edge, it clears the configuration (0), modem (2), auxiliary (3) and power-down (4) registers. It leaves the diagnostic (1), LED (5) and system-control (6) registers unchanged.
- R9: Read data is the register selected by `sel_i`, zero-extended to 32 bits, in the same cycle. Index 7 reads zero. Registers 0–4 are 8 bits wide and store `wdata_i[7:0]`. The LED register (16 bits) and the system-control register (32 bits) decode only `ofs_i == 0`. At any other offset they read zero and ignore writes.
- R10: When a power-down write and a power-fail input change fall in the same cycle, the write's clear is applied first and the input change afterwards. An asserted, enabled input therefore leaves bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (selective, see R8) |
| sel_i | input | 3 | Register index |
| ofs_i | input | OFS_W | Byte offset within the selected register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the selected register |
| pfail_i | input | 1 | External power-fail level |
| irq_o | output | 1 | Power-fail interrupt level |
| tc_o | output | 1 | Floppy terminal-count strobe |
| pwroff_o | output | 1 | Power-off request pulse |
| rstreq_o | output | 1 | System reset request pulse |

## Verification
A wrong latched power-fail bit shows up on `irq_o` one edge after the input change or write that caused it. It also shows when the power-down register is read back in the next cycle. Bad masking or a lost side effect shows on the pulse outputs in the cycle after the write, and on readback straight afterwards. The selective reset is checked by reading every register right after reset, which exposes both a register that was wrongly cleared and one that was wrongly spared.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG   = 3'd0,
    SEL_DIAG  = 3'd1,
    SEL_MODEM = 3'd2,
    SEL_AUX   = 3'd3,
    SEL_PWR   = 3'd4,
    SEL_LED   = 3'd5,
    SEL_SYS   = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  // bit positions that neighbouring logic decodes
  localparam int CFG_EN_BIT  = 3;
  localparam int PWR_OFF_BIT = 0;
  localparam int PWR_CLR_BIT = 1;
  localparam int PWR_PF_BIT  = 5;
  localparam int AUX_TC_BIT  = 1;
  localparam int SYS_GO_BIT  = 0;
  localparam int SYS_STAT    = 2;

endpackage

// File: rtl/sysctl_plainreg.sv
module sysctl_plainreg #(
  parameter int W         = 8,
  parameter bit CLEARABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (CLEARABLE) begin : g_clr
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)       r <= '0;
        else if (we_i) r <= d_i;
      end
      assign q_o = r;
    end else begin : g_keep
      // survives the block reset, only a power-on value
      logic [W-1:0] r = '0;
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) begin
        if (we_i) r <= d_i;
      end
      assign q_o = r;
    end
  endgenerate

endmodule

// File: rtl/sysctl_pwrctl.sv
module sysctl_pwrctl
  import sysctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         pf_i,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pd_o,
  output logic         irq_o,
  output logic         pwroff_o
);

  localparam logic [W-1:0] M_OFF  = W'(1) << PWR_OFF_BIT;
  localparam logic [W-1:0] M_CLR  = W'(1) << PWR_CLR_BIT;
  localparam logic [W-1:0] M_KEEP = M_OFF | M_CLR;

  logic [W-1:0] pd_q, pd_nxt;
  logic         pf_q;
  logic         pf_ev;

  assign pf_ev = pf_i ^ pf_q;

  always_comb begin
    pd_nxt = pd_q;
    if (we_i) begin
      pd_nxt = d_i & M_KEEP;
      pd_nxt[PWR_PF_BIT] = pd_q[PWR_PF_BIT];
      if (d_i[PWR_CLR_BIT]) pd_nxt = pd_nxt & M_OFF;
    end
    // input change is applied after the write
    if (pf_ev) pd_nxt[PWR_PF_BIT] = pf_i & en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q     <= '0;
      pf_q     <= 1'b0;
      pwroff_o <= 1'b0;
    end else begin
      pd_q     <= pd_nxt;
      pf_q     <= pf_i;
      pwroff_o <= we_i & d_i[PWR_OFF_BIT];
    end
  end

  assign pd_o  = pd_q;
  assign irq_o = pd_q[PWR_PF_BIT] & en_i;

  AST_PF_RISE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q[PWR_PF_BIT]) |-> $past(pf_ev && pf_i && en_i)); // R2

  AST_PF_HELD: assert property (@(posedge clk) disable iff (rst)
    (!pf_ev && !(we_i && d_i[PWR_CLR_BIT])) |=> $stable(pd_q[PWR_PF_BIT])); // R3

  AST_CLR_DROPS_PF: assert property (@(posedge clk) disable iff (rst)
    (we_i && d_i[PWR_CLR_BIT] && !pf_ev) |=> !pd_q[PWR_PF_BIT]); // R4

  AST_PWROFF_SRC: assert property (@(posedge clk) disable iff (rst)
    pwroff_o |-> $past(we_i && d_i[PWR_OFF_BIT])); // R5

endmodule

// File: rtl/sysctl_auxctl.sv
module sysctl_auxctl
  import sysctl_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          aux_we_i,
  input  logic [W-1:0]  d_i,
  input  logic          sys_we_i,
  input  logic          sys_go_i,
  output logic [W-1:0]  aux_o,
  output logic [DW-1:0] sys_o,
  output logic          tc_o,
  output logic          rstreq_o
);

  localparam logic [W-1:0]  M_TC     = W'(1) << AUX_TC_BIT;
  localparam logic [DW-1:0] STAT_VAL = DW'(SYS_STAT);

  logic [W-1:0]  aux_q;
  logic [DW-1:0] sys_q = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q <= '0;
      tc_o  <= 1'b0;
    end else begin
      if (aux_we_i) aux_q <= d_i & ~M_TC;
      tc_o <= aux_we_i & d_i[AUX_TC_BIT];
    end
  end

  // status register is not touched by the block reset
  always_ff @(posedge clk) begin
    if (sys_we_i && sys_go_i) sys_q <= STAT_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) rstreq_o <= 1'b0;
    else     rstreq_o <= sys_we_i & sys_go_i;
  end

  assign aux_o = aux_q;
  assign sys_o = sys_q;

  AST_TC_SRC: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> $past(aux_we_i && d_i[AUX_TC_BIT])); // R6

  AST_SYS_NOOP: assert property (@(posedge clk) disable iff (rst)
    (sys_we_i && !sys_go_i) |=> $stable(sys_q)); // R7

  AST_RSTREQ_STAT: assert property (@(posedge clk) disable iff (rst)
    rstreq_o |-> (sys_q == STAT_VAL)); // R7

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LED_W  = 16,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pfail_i,
  output logic              irq_o,
  output logic              tc_o,
  output logic              pwroff_o,
  output logic              rstreq_o
);

  localparam int N_PLAIN = 3; // config, diagnostic, modem

  sel_e sel;
  logic ofs_zero;
  assign sel      = sel_e'(sel_i);
  assign ofs_zero = (ofs_i == '0);

  logic [BYTE_W-1:0] wbyte;
  assign wbyte = wdata_i[BYTE_W-1:0];

  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:LED_W];

  // plain byte registers: index order equals enum order 0..2
  logic [BYTE_W-1:0] plain_q [N_PLAIN];

  generate
    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
      sysctl_plainreg #(
        .W         (BYTE_W),
        .CLEARABLE (i != int'(SEL_DIAG))
      ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .we_i (wr_i && (sel_i == SEL_W'(i))),
        .d_i  (wbyte),
        .q_o  (plain_q[i])
      );
    end
  endgenerate

  logic [LED_W-1:0] led_q;
  sysctl_plainreg #(
    .W         (LED_W),
    .CLEARABLE (1'b0)
  ) u_led (
    .clk  (clk),
    .rst  (rst),
    .we_i (wr_i && sel == SEL_LED && ofs_zero),
    .d_i  (wdata_i[LED_W-1:0]),
    .q_o  (led_q)
  );

  logic [BYTE_W-1:0] pd_q;
  sysctl_pwrctl #(
    .W (BYTE_W)
  ) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .en_i     (plain_q[SEL_CFG][CFG_EN_BIT]),
    .pf_i     (pfail_i),
    .we_i     (wr_i && sel == SEL_PWR),
    .d_i      (wbyte),
    .pd_o     (pd_q),
    .irq_o    (irq_o),
    .pwroff_o (pwroff_o)
  );

  logic [BYTE_W-1:0] aux_q;
  logic [DATA_W-1:0] sys_q;
  sysctl_auxctl #(
    .W  (BYTE_W),
    .DW (DATA_W)
  ) u_aux (
    .clk      (clk),
    .rst      (rst),
    .aux_we_i (wr_i && sel == SEL_AUX),
    .d_i      (wbyte),
    .sys_we_i (wr_i && sel == SEL_SYS && ofs_zero),
    .sys_go_i (wdata_i[SYS_GO_BIT]),
    .aux_o    (aux_q),
    .sys_o    (sys_q),
    .tc_o     (tc_o),
    .rstreq_o (rstreq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CFG:   rdata_o = DATA_W'(plain_q[SEL_CFG]);
      SEL_DIAG:  rdata_o = DATA_W'(plain_q[SEL_DIAG]);
      SEL_MODEM: rdata_o = DATA_W'(plain_q[SEL_MODEM]);
      SEL_AUX:   rdata_o = DATA_W'(aux_q);
      SEL_PWR:   rdata_o = DATA_W'(pd_q);
      SEL_LED:   if (ofs_zero) rdata_o = DATA_W'(led_q);
      SEL_SYS:   if (ofs_zero) rdata_o = sys_q;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;

  localparam int K_RD = 0, K_IRQ = 1, K_TC = 2, K_OFF = 3, K_RST = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  sel = 0;
  logic [1:0]  ofs = 0;
  logic        wr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        pfail = 0;
  logic        irq, tc, pwroff, rstreq;

  always #2.5 clk = ~clk;

  sysctl_regbank i_sysctl_regbank (
    .clk(clk), .rst(rst), .sel_i(sel), .ofs_i(ofs), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .pfail_i(pfail),
    .irq_o(irq), .tc_o(tc), .pwroff_o(pwroff), .rstreq_o(rstreq)
  );

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int c, input int k, input logic [31:0] e, input string t);
    item_t it;
    it.cyc = c; it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  // monitor: pops every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        logic [31:0] got;
        case (sb[i].kind)
          K_RD:    got = rdata;
          K_IRQ:   got = {31'd0, irq};
          K_TC:    got = {31'd0, tc};
          K_OFF:   got = {31'd0, pwroff};
          default: got = {31'd0, rstreq};
        endcase
        n_chk++;
        if (got !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", sb[i].tag, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] o, input logic [31:0] e, input string t);
    sel = s; ofs = o;
    expect_at(cyc, K_RD, e, t);
    step;
  endtask

  // write; returns the cycle index in which the write's effects are visible
  task automatic wrt(input logic [2:0] s, input logic [1:0] o, input logic [31:0] d,
                     input logic pf, output int c1);
    step;
    sel = s; ofs = o; wdata = d; wr = 1; pfail = pf;
    c1 = cyc + 1;
    step;
    wr = 0;
  endtask

  task automatic setpf(input logic v, output int c1);
    step;
    pfail = v;
    c1 = cyc + 1;
    step;
  endtask

  task automatic do_reset;
    step; rst = 1;
    step; step;
    rst = 0;
    step;
  endtask

  initial begin
    int c;
    do_reset;
    // reset state
    rd(3'd0, 0, 32'h0, "R8 cfg after reset");
    rd(3'd2, 0, 32'h0, "R8 modem after reset");
    rd(3'd3, 0, 32'h0, "R8 aux after reset");
    rd(3'd4, 0, 32'h0, "R8 pwrdn after reset");
    expect_at(cyc, K_IRQ, 0, "R1 irq after reset");
    expect_at(cyc, K_RST, 0, "R7 rstreq idle");
    step;

    // scratch storage and widths
    wrt(3'd0, 0, 32'h0000_00A5, 0, c);
    wrt(3'd1, 0, 32'hFFFF_FF5A, 0, c);
    wrt(3'd2, 0, 32'h0000_00C3, 0, c);
    rd(3'd0, 0, 32'hA5, "R9 cfg readback");
    rd(3'd1, 0, 32'h5A, "R9 diag zero-extended");
    rd(3'd2, 2, 32'hC3, "R9 modem readback");
    wrt(3'd5, 0, 32'h0000_BEEF, 0, c);
    wrt(3'd5, 1, 32'h0000_1234, 0, c);
    rd(3'd5, 0, 32'hBEEF, "R9 led offset 0, offset 1 write ignored");
    rd(3'd5, 1, 32'h0, "R9 led other offset reads zero");
    rd(3'd7, 0, 32'h0, "R9 unused index");

    // terminal count
    wrt(3'd3, 0, 32'h0000_00FF, 0, c);
    expect_at(c, K_TC, 1, "R6 tc pulse");
    expect_at(c + 1, K_TC, 0, "R6 tc one cycle");
    rd(3'd3, 0, 32'hFD, "R6 tc bit stored as zero");
    step;
    wrt(3'd3, 0, 32'h0000_0040, 0, c);
    expect_at(c, K_TC, 0, "R6 no tc without bit 1");
    rd(3'd3, 0, 32'h40, "R6 aux readback");

    // power fail while disabled (cfg 0xA5 has bit 3 clear)
    setpf(1, c);
    expect_at(c, K_IRQ, 0, "R2 disabled input");
    rd(3'd4, 0, 32'h0, "R2 bit stays clear when disabled");
    setpf(0, c);
    wrt(3'd0, 0, 32'h08, 0, c);
    setpf(1, c);
    expect_at(c, K_IRQ, 1, "R1 irq with enable");
    rd(3'd4, 0, 32'h20, "R2 latched bit");
    wrt(3'd0, 0, 32'h00, 1, c);
    expect_at(c, K_IRQ, 0, "R1 irq drops with enable");
    rd(3'd4, 0, 32'h20, "R2 bit held without change");
    wrt(3'd0, 0, 32'h08, 1, c);
    expect_at(c, K_IRQ, 1, "R1 irq back with enable");

    // power-down writes
    wrt(3'd4, 0, 32'h0000_00FC, 1, c);
    expect_at(c, K_OFF, 0, "R5 no power off");
    rd(3'd4, 0, 32'h20, "R3 masked write keeps bit 5");
    wrt(3'd4, 0, 32'h02, 1, c);
    expect_at(c, K_IRQ, 0, "R4 irq cleared");
    rd(3'd4, 0, 32'h00, "R4 clear write");
    setpf(0, c);
    setpf(1, c);
    rd(3'd4, 0, 32'h20, "R2 reset by new edge");
    wrt(3'd4, 0, 32'h03, 1, c);
    expect_at(c, K_OFF, 1, "R5 power off pulse");
    expect_at(c + 1, K_OFF, 0, "R5 power off one cycle");
    rd(3'd4, 0, 32'h01, "R4 only power-off bit kept");
    step;
    wrt(3'd4, 0, 32'h01, 1, c);
    expect_at(c, K_OFF, 1, "R5 power off again");
    rd(3'd4, 0, 32'h01, "R3 power-off bit stored");

    // same-cycle ordering
    setpf(0, c);
    wrt(3'd4, 0, 32'h02, 1, c);
    expect_at(c, K_IRQ, 1, "R10 input set after clear");
    rd(3'd4, 0, 32'h20, "R10 bit set");

    // system control
    wrt(3'd6, 0, 32'hFFFF_FFFE, 1, c);
    expect_at(c, K_RST, 0, "R7 no reset request");
    rd(3'd6, 0, 32'h0, "R7 write without bit 0 ignored");
    wrt(3'd6, 2, 32'h1, 1, c);
    expect_at(c, K_RST, 0, "R9 sysctl other offset ignored");
    rd(3'd6, 2, 32'h0, "R9 sysctl other offset reads zero");
    wrt(3'd6, 0, 32'h1, 1, c);
    expect_at(c, K_RST, 1, "R7 reset request pulse");
    expect_at(c + 1, K_RST, 0, "R7 reset request one cycle");
    rd(3'd6, 0, 32'h2, "R7 status value");

    // selective reset
    do_reset;
    rd(3'd0, 0, 32'h0, "R8 cfg cleared");
    rd(3'd1, 0, 32'h5A, "R8 diag kept");
    rd(3'd2, 0, 32'h0, "R8 modem cleared");
    rd(3'd3, 0, 32'h0, "R8 aux cleared");
    rd(3'd4, 0, 32'h0, "R8 pwrdn cleared");
    rd(3'd5, 0, 32'hBEEF, "R8 led kept");
    rd(3'd6, 0, 32'h2, "R8 status kept");
    expect_at(cyc, K_IRQ, 0, "R1 irq after reset");
    step; step;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule